// File: doc/BRIEF.md
# Conversion Timer with Early Interrupt

This block measures out one successive-approximation conversion in units of the converter's core clock. Each core clock arrives as a one-cycle enable tick on the system clock. A start strobe begins a conversion while the block is idle. The conversion then runs for a number of core-clock ticks set by the selected resolution, which is the bit count plus a parameterised overhead of two. When the last tick is consumed, the block pulses an end-of-conversion output.

The block also raises an early-ready pulse a programmable number of core clocks before the end, so that a consumer can start its own work ahead of time. A 3-bit early-select value N asks for a lead of N+1 ticks. The block limits this lead to what fits the chosen resolution. A select value beyond the legal limit is replaced by the largest legal value, without any report. The resolution and early-select inputs are captured when a conversion starts. Any later change to them, and any start strobe that arrives mid-conversion, has no effect until the block is idle again.

Top module: `conv_timer_early`

## Requirements
- R1: While reset is high and in the first cycle after it, `busy_o`, `eoc_o` and `early_o` are all 0.
- R2: A `start_i` sampled high while `busy_o` is 0 sets `busy_o` to 1 from the next cycle. `busy_o` returns to 0 in the cycle after the tick that completes the conversion.
- R3: The resolution code maps as follows: 2'b00 is 6 bits, 2'b01 is 8 bits, 2'b10 is 10 bits and 2'b11 is 12 bits. A conversion consumes bits+2 ticks, which is 8, 10, 12 or 14.
- R4: `eoc_o` is high for exactly one cycle, in the cycle after the final tick. It pulses exactly once per conversion.
- R5: With an effective early-select value N, `early_o` is high for exactly one cycle. That cycle follows the tick after which N+1 ticks remain. It pulses exactly once per conversion.
- R6: The largest legal early-select value is 7 for codes 2'b11 and 2'b10, 5 for 2'b01 and 3 for 2'b00. A larger value behaves as that maximum.
- R7: Changes on `res_i` and `early_sel_i` while `busy_o` is 1 do not alter the running conversion's length or early-pulse timing.
- R8: `start_i` is ignored while `busy_o` is 1.
- R9: `tick_i` has no effect while idle, and no output pulses without a started conversion.
- R10: `early_o` and `eoc_o` are never high in the same cycle, and `early_o` is only high while `busy_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start-of-conversion strobe |
| tick_i | input | 1 | Core-clock enable, one cycle per core clock |
| res_i | input | 2 | Resolution select |
| early_sel_i | input | SEL_W | Early-interrupt lead select |
| busy_o | output | 1 | Conversion in progress |
| eoc_o | output | 1 | End-of-conversion pulse |
| early_o | output | 1 | Early-ready pulse |

## Verification
The hardest situation to reach is a conversion whose early pulse has to be placed correctly while the core ticks arrive irregularly. In the same run, the configuration inputs change and stray start strobes arrive mid-conversion. Random runs therefore gate `tick_i` at random densities. On half of the conversions they also scramble `res_i`, `early_sel_i` and `start_i` on every busy cycle. The bench model then confirms that the pulses follow the values captured at the start. A directed sweep over all 32 resolution and select pairs covers every clamping case.

// File: rtl/cte_pkg.sv
package cte_pkg;

  typedef enum logic [1:0] {
    RES_6  = 2'b00,
    RES_8  = 2'b01,
    RES_10 = 2'b10,
    RES_12 = 2'b11
  } res_e;

  // resolution bit count for a select code
  function automatic int unsigned res_bits(input logic [1:0] code);
    return 6 + 2 * int'(code);
  endfunction

  // largest early-select value allowed at a resolution
  function automatic int unsigned sel_limit(input logic [1:0] code);
    case (code)
      RES_6:   return 3;
      RES_8:   return 5;
      default: return 7;
    endcase
  endfunction

endpackage

// File: rtl/cte_cfg_latch.sv
module cte_cfg_latch #(
  parameter int SEL_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [1:0]       res_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [CNT_W-1:0] lead_o
);
  import cte_pkg::*;

  localparam int unsigned SEL_MAX = (1 << SEL_W) - 1;

  int unsigned      lim;
  int unsigned      sel_eff;
  logic [CNT_W-1:0] lead_d;
  logic [CNT_W-1:0] lead_q;

  always_comb begin
    lim     = (sel_limit(res_i) > SEL_MAX) ? SEL_MAX : sel_limit(res_i);
    sel_eff = (int'(sel_i) > int'(lim)) ? lim : int'(sel_i);
    lead_d  = CNT_W'(sel_eff + 1);
  end

  always_ff @(posedge clk) begin
    if (rst)         lead_q <= '0;
    else if (load_i) lead_q <= lead_d;
  end

  assign lead_o = lead_q;

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> $stable(lead_o)); // R7
  AST_LEAD_NONZERO: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (lead_o != '0)); // R5

endmodule

// File: rtl/cte_tick_counter.sv
module cte_tick_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  input  logic             tick_i,
  output logic [CNT_W-1:0] rem_o,
  output logic             step_o,
  output logic             busy_o
);
  logic [CNT_W-1:0] rem_q;
  logic [CNT_W-1:0] rem_d;
  logic             busy_q;

  always_comb begin
    step_o = 1'b0;
    rem_d  = rem_q;
    if (load_i) begin
      rem_d = len_i;
    end else if (tick_i && rem_q != '0) begin
      step_o = 1'b1;
      rem_d  = rem_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      rem_q  <= rem_d;
      busy_q <= (rem_d != '0);
    end
  end

  assign rem_o  = rem_q;
  assign busy_o = busy_q;

  AST_IDLE_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (rem_q == '0 && !load_i) |=> (rem_q == '0)); // R9
  AST_LOAD_ONLY_IDLE: assert property (@(posedge clk) disable iff (rst)
    load_i |-> !busy_o); // R8

endmodule

// File: rtl/cte_event_gen.sv
module cte_event_gen #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  input  logic [CNT_W-1:0] rem_i,
  input  logic [CNT_W-1:0] lead_i,
  output logic             early_o,
  output logic             eoc_o
);
  logic [CNT_W:0] lead_plus;
  logic           early_q;
  logic           eoc_q;

  assign lead_plus = {1'b0, lead_i} + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      early_q <= 1'b0;
      eoc_q   <= 1'b0;
    end else begin
      early_q <= step_i && ({1'b0, rem_i} == lead_plus);
      eoc_q   <= step_i && (rem_i == CNT_W'(1));
    end
  end

  assign early_o = early_q;
  assign eoc_o   = eoc_q;

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({early_o, eoc_o})); // R10
  AST_EOC_SINGLE: assert property (@(posedge clk) disable iff (rst)
    eoc_o |=> !eoc_o); // R4
  AST_EARLY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    early_o |=> !early_o); // R5

endmodule

// File: rtl/conv_timer_early.sv
module conv_timer_early #(
  parameter  int SEL_W       = 3,
  parameter  int EXTRA_TICKS = 2,
  localparam int MAX_LEN     = 12 + EXTRA_TICKS,
  localparam int MAX_LEAD    = (1 << SEL_W) + 1,
  localparam int CNT_W       = $clog2(((MAX_LEN > MAX_LEAD) ? MAX_LEN : MAX_LEAD) + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             tick_i,
  input  logic [1:0]       res_i,
  input  logic [SEL_W-1:0] early_sel_i,
  output logic             busy_o,
  output logic             eoc_o,
  output logic             early_o
);
  import cte_pkg::*;

  logic             load;
  logic [CNT_W-1:0] len;
  logic [CNT_W-1:0] lead;
  logic [CNT_W-1:0] rem;
  logic             step;
  logic             busy;

  assign load = start_i && !busy;
  assign len  = CNT_W'(res_bits(res_i) + EXTRA_TICKS);

  cte_cfg_latch #(.SEL_W(SEL_W), .CNT_W(CNT_W)) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .res_i  (res_i),
    .sel_i  (early_sel_i),
    .lead_o (lead)
  );

  cte_tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst    (rst),
    .load_i (load),
    .len_i  (len),
    .tick_i (tick_i),
    .rem_o  (rem),
    .step_o (step),
    .busy_o (busy)
  );

  cte_event_gen #(.CNT_W(CNT_W)) u_evt (
    .clk     (clk),
    .rst     (rst),
    .step_i  (step),
    .rem_i   (rem),
    .lead_i  (lead),
    .early_o (early_o),
    .eoc_o   (eoc_o)
  );

  assign busy_o = busy;

  AST_EOC_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    eoc_o |-> (!busy_o && $past(busy_o))); // R2
  AST_EARLY_IN_BUSY: assert property (@(posedge clk) disable iff (rst)
    early_o |-> busy_o); // R10
  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (rst)
    (start_i && !busy_o) |=> busy_o); // R2

endmodule

// File: tb/sim_conv_timer_early.sv
module sim_conv_timer_early;
  logic       clk = 1'b0;
  logic       rst;
  logic       start_i, tick_i;
  logic [1:0] res_i;
  logic [2:0] early_sel_i;
  logic       busy_o, eoc_o, early_o;
  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  conv_timer_early u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .tick_i(tick_i),
    .res_i(res_i), .early_sel_i(early_sel_i),
    .busy_o(busy_o), .eoc_o(eoc_o), .early_o(early_o)
  );

  function automatic int exp_len(int r);
    return 8 + 2 * r;
  endfunction

  function automatic int exp_lead(int r, int s);
    int lim;
    lim = (r == 0) ? 3 : (r == 1) ? 5 : 7;
    return ((s > lim) ? lim : s) + 1;
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_conv(int r, int s, int pct, bit noise);
    int rem, lead, ne, nx;
    bit t, xe, xx;
    @(negedge clk);
    start_i = 1'b1; res_i = 2'(r); early_sel_i = 3'(s);
    tick_i = ($urandom % 100) < 50;
    @(negedge clk);
    start_i = 1'b0;
    chk(busy_o == 1'b1, "R2 busy after start", int'(busy_o), 1);
    chk(!early_o && !eoc_o, "R5 no pulse at start", int'(early_o | eoc_o), 0);
    rem = exp_len(r); lead = exp_lead(r, s); ne = 0; nx = 0;
    while (rem > 0) begin
      t = ($urandom % 100) < pct;
      tick_i = t;
      if (noise) begin
        res_i = 2'($urandom); early_sel_i = 3'($urandom);
        start_i = $urandom % 2;
      end
      @(negedge clk);
      if (t) rem--;
      xe = t && (rem == lead);
      xx = t && (rem == 0);
      chk(early_o == xe, noise ? "R5 R6 R7 R8 early" : "R5 R6 early", int'(early_o), int'(xe));
      chk(eoc_o == xx, noise ? "R3 R4 R7 R8 eoc" : "R3 R4 eoc", int'(eoc_o), int'(xx));
      chk(busy_o == (rem != 0), "R2 busy", int'(busy_o), int'(rem != 0));
      chk(!(early_o && eoc_o), "R10 exclusive", 1, 0);
      ne += early_o; nx += eoc_o;
    end
    start_i = 1'b0; tick_i = 1'b0;
    chk(ne == 1, "R5 single early", ne, 1);
    chk(nx == 1, "R4 single eoc", nx, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog R2 actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; start_i = 1'b1; tick_i = 1'b1; res_i = 2'b11; early_sel_i = 3'd7;
    repeat (3) @(negedge clk);
    chk(!busy_o && !eoc_o && !early_o, "R1 reset outputs", int'({busy_o, eoc_o, early_o}), 0);
    start_i = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    chk(!busy_o && !eoc_o && !early_o, "R1 after reset", int'({busy_o, eoc_o, early_o}), 0);
    // R9: ticks while idle do nothing
    for (int i = 0; i < 20; i++) begin
      tick_i = $urandom % 2;
      @(negedge clk);
      chk(!busy_o && !eoc_o && !early_o, "R9 idle ticks", int'({busy_o, eoc_o, early_o}), 0);
    end
    tick_i = 1'b0;
    // R3 R6: every resolution and select pair, dense ticks
    for (int r = 0; r < 4; r++)
      for (int s = 0; s < 8; s++)
        run_conv(r, s, 100, 1'b0);
    // random density, half with scrambled inputs (R7 R8)
    for (int k = 0; k < 300; k++)
      run_conv($urandom % 4, $urandom % 8, 20 + ($urandom % 81), $urandom % 2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule